// File: doc/BRIEF.md
# Oversampled serial receiver with FIFO-driven flow control

This block is the receive path of one asynchronous serial channel. It watches a serial line with a 16x sampling enable, which is produced elsewhere from the baud divisor. It confirms a start bit near the middle of the bit, and it assembles a character of 5 to 8 bits with the least significant bit first. It can check an optional even or odd parity bit. It then samples the stop bit. Each finished character goes into a 16-entry first-word-fall-through queue, together with its parity, framing and break flags. Because the flags are stored with the byte, they appear at the read port only when that byte reaches the head of the queue.

A host pops entries through a single read strobe. The queue fill level is compared against a selectable trigger level. Reaching that level raises a receive interrupt. In automatic mode it also drops the ready-to-send output, so the far transmitter pauses. Once the queue drains below the trigger, the output is raised again. In manual mode the ready-to-send output follows a host-owned request bit.

Top module: `uart_rx_flow`

## Requirements
- R1: After reset the queue is empty (`fifo_level`=0, `rd_valid`=0), `rx_irq` is low, and with automatic mode selected `rts_o` is high.
- R2: A low level that has returned high by the 8th sampling tick after it was first seen is rejected as a false start. It produces no entry, and the receiver looks for a new start afterwards.
- R3: `cfg_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first, and the unused upper bits of `rd_data` read as zero.
- R4: With `cfg_par_en`=1 a parity bit follows the data. If `cfg_par_even`=1 the parity is even, and if it is 0 the parity is odd. A parity mismatch sets `rd_par_err` on that entry, and the received data is still stored.
- R5: A stop bit sampled low sets `rd_frm_err` on that entry.
- R6: A line held low through the whole frame, stop position included, stores exactly one entry. That entry has data 0x00, `rd_brk`=1, `rd_frm_err`=1 and `rd_par_err`=0. No further entry appears until the line has gone high again.
- R7: The queue holds 16 entries in arrival order and presents its head without a read. `rd_en` removes the head, and `rd_en` on an empty queue has no effect.
- R8: A character that completes while the queue holds 16 entries is dropped. `overrun` pulses high for one cycle, and the queue contents stay unchanged.
- R9: `cfg_trig` selects the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. `rx_irq` is high exactly while `fifo_level` is at or above the trigger level.
- R10: With `cfg_auto_rts`=1, `rts_o` is low while `fifo_level` is at or above the trigger level and high while it is below.
- R11: With `cfg_auto_rts`=0, `rts_o` equals `sw_rts`, whatever the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Sampling enable, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_trig | input | 2 | Trigger level select |
| cfg_auto_rts | input | 1 | 1 = automatic ready-to-send control |
| sw_rts | input | 1 | Ready-to-send value in manual mode |
| rd_en | input | 1 | Pop the head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head entry data |
| rd_par_err | output | 1 | Head entry parity error |
| rd_frm_err | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| fifo_level | output | 5 | Entries held |
| overrun | output | 1 | One-cycle pulse on a dropped character |
| rx_irq | output | 1 | Fill level at or above trigger |
| rts_o | output | 1 | Ready-to-send, high = may send |

## Verification
A receiver stuck in a wrong state shows up within one frame. Either `fifo_level` fails to rise after the stop bit, or the head data is shifted or masked incorrectly. A stale parity or zero tracker shows as a wrong flag at the head, which is visible as soon as that entry is first in the queue. A level counter or pointer that goes wrong shows on `rx_irq` and `rts_o` on the next push. It also shows on the read order of a full queue as it is drained, so sweeping every trigger setting through a fill and a drain exposes it within 17 frames.

// File: rtl/uart_rx_pkg.sv
// Shared types and decode helpers for the serial receive path.
// Assumes an 8-bit data field; shorter characters are zero-extended.
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    // Map the 2-bit trigger select onto a fill threshold.
    function automatic logic [7:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd1;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
// Character framer: synchronises the line, qualifies the start bit at
// mid-bit, samples data/parity/stop once per bit at the centre and emits one
// entry per frame with its error flags. Assumes tick is a one-cycle enable
// occurring OSR times per bit period and SYNC_STAGES >= 2.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx_in,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_even,
    output logic      push_o,
    output rx_entry_t entry_o
);

    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_t              state;
    logic [CNT_W-1:0]       cnt;
    logic [2:0]             bit_idx;
    logic [2:0]             last_idx;
    logic [DATA_W-1:0]      data_q;
    logic                   ones_q;
    logic                   all_zero_q;
    logic                   par_bad_q;
    logic                   is_brk;

    // Bring the asynchronous line into the clock domain (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end

    assign rx_s     = sync_q[SYNC_STAGES-1];
    assign last_idx = 3'd4 + {1'b0, cfg_len};
    assign is_brk   = !rx_s && all_zero_q;

    // Frame state machine, advanced only on sampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            data_q     <= '0;
            ones_q     <= 1'b0;
            all_zero_q <= 1'b1;
            par_bad_q  <= 1'b0;
            push_o     <= 1'b0;
            entry_o    <= '0;
        end else begin
            push_o <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID_CNT) begin
                            cnt <= '0;
                            if (rx_s) begin
                                state <= ST_IDLE;
                            end else begin
                                state      <= ST_DATA;
                                bit_idx    <= '0;
                                data_q     <= '0;
                                ones_q     <= 1'b0;
                                all_zero_q <= 1'b1;
                                par_bad_q  <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST_CNT) begin
                            cnt             <= '0;
                            data_q[bit_idx] <= rx_s;
                            ones_q          <= ones_q ^ rx_s;
                            if (rx_s) all_zero_q <= 1'b0;
                            if (bit_idx == last_idx)
                                state <= cfg_par_en ? ST_PAR : ST_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST_CNT) begin
                            cnt       <= '0;
                            par_bad_q <= rx_s != (cfg_par_even ? ones_q : ~ones_q);
                            if (rx_s) all_zero_q <= 1'b0;
                            state     <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST_CNT) begin
                            cnt          <= '0;
                            push_o       <= 1'b1;
                            entry_o.brk  <= is_brk;
                            entry_o.frm  <= !rx_s;
                            entry_o.par  <= par_bad_q && !is_brk;
                            entry_o.data <= is_brk ? '0 : data_q;
                            state        <= rx_s ? ST_IDLE : ST_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (rx_s) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
// First-word-fall-through queue of received entries. A push into a full
// queue is dropped (unless a pop frees a slot the same cycle) and reported
// by a registered one-cycle pulse. Pops on an empty queue are ignored.
module uart_rx_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic             ovr_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_pop;
    logic             do_push;

    assign do_pop  = pop && (level != '0);
    assign do_push = push && ((level != LVL_FULL) || do_pop);
    assign dout    = mem[rd_ptr];

    // Store accepted entries.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Maintain pointers, occupancy and the overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovr_o  <= 1'b0;
        end else begin
            ovr_o <= push && !do_push;
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_rts.sv
// Threshold logic: decodes the trigger select, raises the receive interrupt
// at or above it and drives ready-to-send from the level in automatic mode.
// Assumes level comes straight from the queue occupancy register.
module uart_rx_rts
    import uart_rx_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       cfg_trig,
    input  logic             cfg_auto,
    input  logic             sw_rts,
    output logic             irq_o,
    output logic             rts_o
);

    logic [LVL_W-1:0] thresh;
    logic             at_trig;

    // Compare occupancy with the selected threshold and pick the RTS source.
    always_comb begin
        thresh  = LVL_W'(trig_level(cfg_trig));
        at_trig = level >= thresh;
        irq_o   = at_trig;
        rts_o   = cfg_auto ? !at_trig : sw_rts;
    end

endmodule

// File: rtl/uart_rx_flow.sv
// Top of the receive path: framer feeding a flagged entry queue, with
// threshold-driven interrupt and ready-to-send. tick16 must come from an
// external baud divisor at OSR pulses per bit.
module uart_rx_flow
    import uart_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rx_in,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_even,
    input  logic [1:0]       cfg_trig,
    input  logic             cfg_auto_rts,
    input  logic             sw_rts,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rd_par_err,
    output logic             rd_frm_err,
    output logic             rd_brk,
    output logic [LVL_W-1:0] fifo_level,
    output logic             overrun,
    output logic             rx_irq,
    output logic             rts_o
);

    localparam int ENTRY_W = $bits(rx_entry_t);

    logic      push_w;
    rx_entry_t entry_w;
    rx_entry_t head_w;

    uart_rx_frame #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .rx_in        (rx_in),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .push_o       (push_w),
        .entry_o      (entry_w)
    );

    uart_rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_w),
        .din   (entry_w),
        .pop   (rd_en),
        .dout  (head_w),
        .level (fifo_level),
        .ovr_o (overrun)
    );

    uart_rx_rts #(.LVL_W(LVL_W)) u_rts (
        .level    (fifo_level),
        .cfg_trig (cfg_trig),
        .cfg_auto (cfg_auto_rts),
        .sw_rts   (sw_rts),
        .irq_o    (rx_irq),
        .rts_o    (rts_o)
    );

    assign rd_valid   = fifo_level != '0;
    assign rd_data    = head_w.data;
    assign rd_par_err = head_w.par;
    assign rd_frm_err = head_w.frm;
    assign rd_brk     = head_w.brk;

endmodule

// File: rtl/uart_rx_flow_chk.sv
// Property checker for the receive path, bound to every uart_rx_flow.
module uart_rx_flow_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_w,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic             rd_par_err,
    input logic             rd_frm_err,
    input logic             rd_brk,
    input logic [LVL_W-1:0] fifo_level,
    input logic             overrun,
    input logic             rx_irq,
    input logic             rts_o,
    input logic             cfg_auto_rts,
    input logic             sw_rts
);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH)); // R7
    AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (fifo_level != '0)); // R7
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_valid && !push_w |=> fifo_level == '0); // R7
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_valid && !push_w |=> fifo_level == $past(fifo_level) - 1'b1); // R7
    AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> fifo_level == LVL_W'(DEPTH)); // R8
    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $stable(fifo_level)); // R8
    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_brk |-> rd_frm_err && !rd_par_err && rd_data == 8'h00); // R6
    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level == '0 |-> !rx_irq); // R9
    AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_auto_rts && fifo_level == LVL_W'(DEPTH) |-> !rts_o); // R10
    AST_RTS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_auto_rts && fifo_level == '0 |-> rts_o); // R10
    AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_auto_rts |-> rts_o == sw_rts); // R11

endmodule

bind uart_rx_flow uart_rx_flow_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_w       (push_w),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_par_err   (rd_par_err),
    .rd_frm_err   (rd_frm_err),
    .rd_brk       (rd_brk),
    .fifo_level   (fifo_level),
    .overrun      (overrun),
    .rx_irq       (rx_irq),
    .rts_o        (rts_o),
    .cfg_auto_rts (cfg_auto_rts),
    .sw_rts       (sw_rts)
);

// File: tb/uart_rx_flow_tb_top.sv
// Self-checking bench: sweeps lengths, parity modes and trigger levels,
// and injects false starts, parity/framing errors, break and overrun.
module uart_rx_flow_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic [1:0] cfg_trig = 2'd0;
    logic       cfg_auto_rts = 1'b1;
    logic       sw_rts = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_par_err;
    logic       rd_frm_err;
    logic       rd_brk;
    logic [4:0] fifo_level;
    logic       overrun;
    logic       rx_irq;
    logic       rts_o;

    int n_cmp = 0;
    int n_bad = 0;
    int ovr_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Sampling enable every second cycle, only once out of reset.
    always @(negedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

    // Count overrun pulses seen at the port.
    always @(posedge clk) if (rst_n && overrun) ovr_cnt <= ovr_cnt + 1;

    uart_rx_flow dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_trig(cfg_trig), .cfg_auto_rts(cfg_auto_rts), .sw_rts(sw_rts),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err), .rd_brk(rd_brk),
        .fifo_level(fifo_level), .overrun(overrun), .rx_irq(rx_irq), .rts_o(rts_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic line(input logic v, input int ticks);
        rx_in = v;
        repeat (ticks * 2) @(negedge clk);
    endtask

    task automatic send_char(input int len, input logic [7:0] d, input logic pen,
                             input logic peven, input logic flip, input logic stop_v);
        logic [7:0] m;
        logic       p;
        m = 8'((1 << len) - 1);
        p = ^(d & m);
        line(1'b0, 16);
        for (int i = 0; i < len; i++) line(d[i], 16);
        if (pen) line((peven ? p : ~p) ^ flip, 16);
        line(stop_v, 16);
        if (!stop_v) line(1'b1, 8);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Compare the head entry with expected fields, then pop it.
    task automatic take(input string req, input int d, input int pe, input int fe, input int bk);
        chk({req, " data"}, rd_data, d);
        chk({req, " par"}, rd_par_err, pe);
        chk({req, " frm"}, rd_frm_err, fe);
        chk({req, " brk"}, rd_brk, bk);
        pop();
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] vals [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", fifo_level, 0);
        chk("R1 valid", rd_valid, 0);
        chk("R1 irq", rx_irq, 0);
        chk("R1 rts", rts_o, 1);
        line(1'b1, 4);

        // R3 and R4: every length, parity mode and pattern
        for (int l = 0; l < 4; l++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int v = 0; v < 5; v++) begin
                    cfg_len = 2'(l);
                    cfg_par_en = pm != 0;
                    cfg_par_even = pm == 2;
                    send_char(l + 5, vals[v], cfg_par_en, cfg_par_even, 1'b0, 1'b1);
                    chk("R3 level", fifo_level, 1);
                    take("R3", vals[v] & 8'((1 << (l + 5)) - 1), 0, 0, 0);
                    chk("R7 drained", fifo_level, 0);
                end
            end
        end

        // R4 parity errors in both senses, data kept
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        send_char(8, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1);
        take("R4 even", 8'h5A, 1, 0, 0);
        cfg_par_even = 1'b0;
        send_char(8, 8'hC3, 1'b1, 1'b0, 1'b1, 1'b1);
        take("R4 odd", 8'hC3, 1, 0, 0);

        // R5 framing error
        cfg_par_en = 1'b0;
        send_char(8, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 level", fifo_level, 1);
        take("R5", 8'h55, 0, 1, 0);

        // R6 break with parity on: one entry only
        cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        line(1'b0, 16 * 30);
        line(1'b1, 16);
        chk("R6 level", fifo_level, 1);
        take("R6", 0, 0, 1, 1);
        chk("R6 single", fifo_level, 0);
        cfg_par_en = 1'b0;

        // R2 false starts, then a real character
        line(1'b0, 3);
        line(1'b1, 30);
        line(1'b0, 5);
        line(1'b1, 30);
        chk("R2 no entry", fifo_level, 0);
        send_char(8, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
        take("R2 recover", 8'h81, 0, 0, 0);

        // R7 pop on empty ignored
        pop();
        chk("R7 empty pop", fifo_level, 0);
        chk("R7 empty valid", rd_valid, 0);

        // R9 R10 R8: each trigger level through fill, overrun and drain
        for (int t = 0; t < 4; t++) begin
            int thr;
            int o0;
            cfg_trig = 2'(t);
            thr = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
            for (int k = 1; k <= 16; k++) begin
                send_char(8, 8'(k), 1'b0, 1'b0, 1'b0, 1'b1);
                chk("R9 irq fill", rx_irq, int'(k >= thr));
                chk("R10 rts fill", rts_o, int'(k < thr));
            end
            o0 = ovr_cnt;
            send_char(8, 8'd99, 1'b0, 1'b0, 1'b0, 1'b1);
            chk("R8 pulses", ovr_cnt - o0, 1);
            chk("R8 level", fifo_level, 16);
            for (int k = 1; k <= 16; k++) begin
                take("R7 order", k, 0, 0, 0);
                chk("R9 irq drain", rx_irq, int'((16 - k) >= thr));
                chk("R10 rts drain", rts_o, int'((16 - k) < thr));
            end
        end

        // R11 manual mode overrides the level
        cfg_trig = 2'd0;
        cfg_auto_rts = 1'b0;
        sw_rts = 1'b1;
        send_char(8, 8'h42, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R11 hi", rts_o, 1);
        sw_rts = 1'b0;
        @(negedge clk);
        chk("R11 lo", rts_o, 0);
        take("R11 data", 8'h42, 0, 0, 0);
        chk("R11 empty", rts_o, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule